// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a single-stage datapath element. It combines three result paths, arithmetic, bitwise logic and one-position shift, and a destination register that captures the chosen result. A 4-bit operation select and a carry input pick the function. The upper two select bits choose the path. The lower two select bits and the carry input then pick the operation inside the arithmetic or logic path.

The arithmetic path is one adder. Its first operand is always A. Its second operand comes from a four-way multiplexer that supplies zeros, B, the complement of B, or all ones. The carry input feeds the adder's carry-in. With this one adder the path covers transfer, increment, add, add with carry, subtract with borrow, subtract and decrement. A final per-bit multiplexer merges the paths. When the load control is high, the result and a carry-out are registered on the rising clock edge.

Top module: `alsu_core`

## Requirements
- R1: While the active-low reset is low, and in the first cycle after it is released, the result register reads 0 and the carry-out register reads 0.
- R2: With sel[3:2] = 00 the result is the low WIDTH bits of A + Y + carry_in. Y is chosen by sel[1:0]: 00 zeros, 01 B, 10 NOT B, 11 all ones. This gives A, A+1, A+B, A+B+1, A+B', A-B, A-1, and A for the eight values of {sel[1:0], carry_in}.
- R3: On arithmetic codes the carry-out is bit WIDTH of the (WIDTH+1)-bit sum A + Y + carry_in.
- R4: With sel[3:2] = 01 the result is bitwise: sel[1:0] 00 AND, 01 OR, 10 XOR, 11 NOT A. carry_in has no effect.
- R5: With sel[3:2] = 10 the result is A shifted right by one, with 0 in the top bit. sel[1:0] and carry_in have no effect.
- R6: With sel[3:2] = 11 the result is A shifted left by one, with 0 in the bottom bit. sel[1:0] and carry_in have no effect.
- R7: On every logic and shift code the registered carry-out is 0.
- R8: When load_en is low at a rising edge, neither the result register nor the carry-out register changes, whatever the other inputs do.
- R9: A result is visible on the outputs from the rising edge at which load_en is high. Before that edge the outputs keep the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load control for the destination register |
| sel | input | 4 | Operation select; [3:2] path, [1:0] operation |
| carry_in | input | 1 | Adder carry input |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| f_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry-out |

## Verification
Two things can happen in the same cycle: a new result is loaded while the operands and select already move toward the next operation. A rising edge with load_en high can also coincide with an arithmetic code that wraps past the top, such as an increment of all ones or a transfer with carry_in high. In both cases the new sum and the carry-out must arrive at the same edge. The bench changes the operands in the cycle after a load and also with load_en held low, and it samples the registers half a period after each edge. Before the loading edge the old value must still be present. After it, the computed sum and carry must appear together.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    localparam int SEL_W = 4;

    // Path chosen by the upper select bits
    typedef enum logic [1:0] {
        PATH_ARITH = 2'b00,
        PATH_LOGIC = 2'b01,
        PATH_SHR   = 2'b10,
        PATH_SHL   = 2'b11
    } path_e;

    // Second adder operand chosen by the lower select bits
    typedef enum logic [1:0] {
        YSRC_ZERO = 2'b00,
        YSRC_B    = 2'b01,
        YSRC_NOTB = 2'b10,
        YSRC_ONES = 2'b11
    } ysrc_e;

    // Bitwise function chosen by the lower select bits
    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op,
    input  logic             cin,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] y_opnd;
    logic [SUM_W-1:0] total;

    // Second operand selection feeding the single adder (R2)
    always_comb begin
        unique case (ysrc_e'(op))
            YSRC_ZERO: y_opnd = '0;
            YSRC_B:    y_opnd = b;
            YSRC_NOTB: y_opnd = ~b;
            YSRC_ONES: y_opnd = '1;
            default:   y_opnd = '0;
        endcase
    end

    always_comb begin
        total = {1'b0, a} + {1'b0, y_opnd} + {{(SUM_W-1){1'b0}}, cin};
        sum   = total[WIDTH-1:0];
        carry = total[WIDTH];
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    // Bitwise function selection (R4)
    always_comb begin
        unique case (lop_e'(op))
            LOP_AND:  y = a & b;
            LOP_OR:   y = a | b;
            LOP_XOR:  y = a ^ b;
            LOP_NOTA: y = ~a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    output logic [WIDTH-1:0] shr_y,
    output logic [WIDTH-1:0] shl_y
);

    // One-position shifts with zero fill at the vacated end (R5, R6)
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            assign shr_y[i] = 1'b0;
        end else begin : g_top_n
            assign shr_y[i] = a[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl_y[i] = 1'b0;
        end else begin : g_bot_n
            assign shl_y[i] = a[i-1];
        end
    end

endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [3:0]       sel,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] f_q,
    output logic             cout_q
);

    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             cout;
    } dest_t;

    dest_t state_d, state_q;

    logic [WIDTH-1:0] arith_y, logic_y, shr_y, shl_y;
    logic             arith_c;
    path_e            path;

    assign path = path_e'(sel[3:2]);

    alsu_arith #(.WIDTH(WIDTH)) i_arith (
        .op    (sel[1:0]),
        .cin   (carry_in),
        .a     (a_in),
        .b     (b_in),
        .sum   (arith_y),
        .carry (arith_c)
    );

    alsu_logic #(.WIDTH(WIDTH)) i_logic (
        .op (sel[1:0]),
        .a  (a_in),
        .b  (b_in),
        .y  (logic_y)
    );

    alsu_shift #(.WIDTH(WIDTH)) i_shift (
        .a     (a_in),
        .shr_y (shr_y),
        .shl_y (shl_y)
    );

    // Next-state: final path merge and load control
    always_comb begin
        state_d = state_q;
        if (load_en) begin
            unique case (path)
                PATH_ARITH: begin
                    state_d.f    = arith_y;
                    state_d.cout = arith_c;
                end
                PATH_LOGIC: begin
                    state_d.f    = logic_y;
                    state_d.cout = 1'b0;
                end
                PATH_SHR: begin
                    state_d.f    = shr_y;
                    state_d.cout = 1'b0;
                end
                PATH_SHL: begin
                    state_d.f    = shl_y;
                    state_d.cout = 1'b0;
                end
                default: begin
                    state_d.f    = '0;
                    state_d.cout = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign f_q    = state_q.f;
    assign cout_q = state_q.cout;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(f_q) && $stable(cout_q)));

    p_cout_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && sel[3:2] != 2'b00) |=> !cout_q);

    p_shr_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && sel[3:2] == 2'b10) |=> !f_q[WIDTH-1]);

    p_shl_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && sel[3:2] == 2'b11) |=> !f_q[0]);

    p_transfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && sel == 4'b0011 && carry_in) |=> (f_q == $past(a_in) && cout_q));

endmodule

// File: tb/test_alsu_core.sv
`timescale 1ns/1ps
module test_alsu_core;

    localparam int W = 8;

    // {sel, cin, a, b, exp_f, exp_c}
    typedef struct packed {
        logic [3:0]   sel;
        logic         cin;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] ef;
        logic         ec;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 1'b0, 8'hC5, 8'h3A, 8'hC5, 1'b0}, // R2 transfer
        '{4'b0000, 1'b1, 8'hC5, 8'h3A, 8'hC6, 1'b0}, // R2 increment
        '{4'b0001, 1'b0, 8'hC5, 8'h3A, 8'hFF, 1'b0}, // R2 add
        '{4'b0001, 1'b1, 8'hC5, 8'h3A, 8'h00, 1'b1}, // R3 add carry wrap
        '{4'b0010, 1'b0, 8'hC5, 8'h3A, 8'h8A, 1'b1}, // R2 sub borrow
        '{4'b0010, 1'b1, 8'hC5, 8'h3A, 8'h8B, 1'b1}, // R2 subtract
        '{4'b0011, 1'b0, 8'hC5, 8'h3A, 8'hC4, 1'b1}, // R2 decrement
        '{4'b0011, 1'b1, 8'hC5, 8'h3A, 8'hC5, 1'b1}, // R3 transfer carry
        '{4'b0100, 1'b1, 8'hC5, 8'h0F, 8'h05, 1'b0}, // R4 AND
        '{4'b0101, 1'b0, 8'hC5, 8'h0F, 8'hCF, 1'b0}, // R4 OR
        '{4'b0110, 1'b1, 8'hC5, 8'h0F, 8'hCA, 1'b0}, // R4 XOR
        '{4'b0111, 1'b0, 8'hC5, 8'h0F, 8'h3A, 1'b0}, // R4 NOT A
        '{4'b1000, 1'b0, 8'hC5, 8'h00, 8'h62, 1'b0}, // R5 shr
        '{4'b1011, 1'b1, 8'hC5, 8'hFF, 8'h62, 1'b0}, // R5 don't-care bits
        '{4'b1100, 1'b0, 8'hC5, 8'h00, 8'h8A, 1'b0}, // R6 shl
        '{4'b1111, 1'b1, 8'hC5, 8'hFF, 8'h8A, 1'b0}, // R6 don't-care bits
        '{4'b0011, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b0}, // R3 decrement of zero
        '{4'b0000, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1}, // R3 increment wrap
        '{4'b1000, 1'b1, 8'h81, 8'h00, 8'h40, 1'b0}, // R5 top fill
        '{4'b1100, 1'b1, 8'h81, 8'h00, 8'h02, 1'b0}, // R6 bottom fill
        '{4'b0100, 1'b1, 8'hFF, 8'hA5, 8'hA5, 1'b0}  // R7 logic carry zero
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [3:0]   sel = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] f_q;
    logic         cout_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alsu_core #(.WIDTH(W)) i_alsu_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .sel      (sel),
        .carry_in (carry_in),
        .a_in     (a_in),
        .b_in     (b_in),
        .f_q      (f_q),
        .cout_q   (cout_q)
    );

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic [3:0] s, input logic c,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        load_en  = ld;
        sel      = s;
        carry_in = c;
        a_in     = a;
        b_in     = b;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with load requested during reset
        drive(1'b1, 4'b0001, 1'b1, 8'hFF, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", {cout_q, f_q}, {1'b0, 8'h00});
        drive(1'b0, 4'b0000, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 after release", {cout_q, f_q}, {1'b0, 8'h00});

        // Table walk
        for (int k = 0; k < NV; k++) begin
            drive(1'b1, VECS[k].sel, VECS[k].cin, VECS[k].a, VECS[k].b);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2-table vec %0d", k), {cout_q, f_q}, {VECS[k].ec, VECS[k].ef});
        end

        // R8: load low, inputs move, state held
        drive(1'b1, 4'b0001, 1'b1, 8'hFF, 8'h00);   // loads 00 with carry 1
        @(posedge clk);
        @(negedge clk);
        chk("R3 setup", {cout_q, f_q}, {1'b1, 8'h00});
        drive(1'b0, 4'b0111, 1'b0, 8'h12, 8'h34);
        @(posedge clk);
        @(negedge clk);
        chk("R8 hold 1", {cout_q, f_q}, {1'b1, 8'h00});
        drive(1'b0, 4'b1100, 1'b1, 8'h55, 8'hAA);
        @(posedge clk);
        @(negedge clk);
        chk("R8 hold 2", {cout_q, f_q}, {1'b1, 8'h00});

        // R9: new operands presented, old value until the loading edge
        drive(1'b1, 4'b0010, 1'b1, 8'h10, 8'h01);   // 10 - 01 = 0F, carry 1
        #1;
        chk("R9 before edge", {cout_q, f_q}, {1'b1, 8'h00});
        @(posedge clk);
        @(negedge clk);
        chk("R9 after edge", {cout_q, f_q}, {1'b1, 8'h0F});
        // Back-to-back load with operands changing each cycle
        drive(1'b1, 4'b0110, 1'b1, 8'hF0, 8'h3C);   // XOR = CC, carry 0
        @(posedge clk);
        @(negedge clk);
        chk("R7 back-to-back", {cout_q, f_q}, {1'b0, 8'hCC});

        // R4: carry_in has no effect on logic
        drive(1'b1, 4'b0111, 1'b1, 8'h0F, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R4 cin ignored", {cout_q, f_q}, {1'b0, 8'hF0});

        // R1: reset mid-stream clears state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid reset", {cout_q, f_q}, {1'b0, 8'h00});
        rst_n = 1'b1;
        drive(1'b0, 4'b0000, 1'b0, 8'h00, 8'h00);
        @(posedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule